// File: doc/BRIEF.md
# Analog Input Sequencer with Channel List

This block is the register-side controller of a 16-channel analog input path. A host programs it through a small 16-bit register window. On each address, a write and a read mean different things. The host loads a list of conversion entries. Each entry names a channel, a gain code, a polarity and a reference mode. The host then picks one of four trigger modes. The block walks the list and hands each entry to an external converter through a start/done handshake. It stores the returned 12-bit samples in a result FIFO, and the host reads them back in offset-binary form.

The register window has four word offsets:
- Offset 0: a write sets the control word. A read is the software start strobe, and its data is zero.
- Offset 1: a write sets the FIFO-enable word. A read returns zero.
- Offset 2: a read returns status. Any write clears the pending interrupt flags.
- Offset 3: a write appends a channel-list entry. A read pops one result.

There is no back-pressure anywhere. The converter's done pulse is always taken. A sample that arrives while the result FIFO is full is dropped and counted as an overflow. Reads take effect in the cycle in which `bus_rd` is high, and `bus_rdata` is valid combinationally in that same cycle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control-word bits [1:0] select the mode: 0 off, 1 software, 2 scan, 3 external. In mode 0, no trigger of any kind produces `conv_start`.
- R2: In mode 1, a read of offset 0 launches exactly one conversion. The read returns 0. `conv_start` is a single-cycle pulse that is high in the cycle after the read. In this mode `scan_tick` and `ext_trig` have no effect.
- R3: A list entry is 8 bits: [3:0] channel, [5:4] gain, bit 6 unipolar, bit 7 differential. These fields appear on `conv_chan`, `conv_gain`, `conv_unipolar` and `conv_diff` together with `conv_start`.
- R4: The channel list holds 16 entries. Each launch consumes the entry at the cursor. After the last written entry, the cursor wraps to entry 0. A write to a full list is dropped.
- R5: In mode 2, a `scan_tick` pulse converts every list entry once, in order, back-to-back, starting at the cursor.
- R6: In mode 3, a rising edge of `ext_trig` launches one conversion. Holding the input high does not launch further conversions.
- R7: A trigger is ignored while a conversion or scan is in flight, and also while the channel list is empty.
- R8: A read of offset 3 pops the oldest sample and returns it with bit 11 inverted in [11:0] and zeros in [15:12]. A read while the FIFO is empty returns 0 and changes nothing.
- R9: Status bits: 0 sequencer active, 1 list full, 2 results empty, 3 results at least half full (16 or more), 4 results full, 5 overflow, 8 half-full interrupt pending, 9 external interrupt pending. All other bits read 0.
- R10: The result FIFO holds 32 samples. A sample arriving while it is full is dropped and sets the overflow bit. The overflow bit stays set until the result FIFO is disabled.
- R11: Bit 10 of the FIFO-enable word enables the result FIFO, and bit 9 enables the channel list. While a bit is clear, its FIFO is emptied and held empty, and list writes are dropped.
- R12: When control bit 8 is set, the half-full flag's rising edge sets pending bit 8. When control bit 9 is set, an `ext_trig` rising edge sets pending bit 9. `irq` equals control bit 15 ANDed with the OR of the pending bits.
- R13: Any write to offset 2 clears both pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register word offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; carries side effects |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| scan_tick | input | 1 | Scan trigger pulse from an external timer |
| ext_trig | input | 1 | External trigger level, synchronous to clk |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel of the request |
| conv_gain | output | 2 | Gain code of the request |
| conv_unipolar | output | 1 | Unipolar flag of the request |
| conv_diff | output | 1 | Differential-reference flag of the request |
| conv_done | input | 1 | One-cycle sample-ready pulse from the converter |
| conv_sample | input | 12 | Sample that accompanies conv_done |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the converter:
- It answers each `conv_start` with exactly one `conv_done`.
- That `conv_done` never falls in the same cycle as the `conv_start`, nor in the cycle directly after it.
- It sends no `conv_done` while the sequencer is idle.
- `ext_trig` is already synchronous to the clock.

The bench's converter model meets these rules. It waits two cycles after seeing each start and then returns one done pulse carrying a sample built from the request fields. The bench toggles the triggers only while the block is idle, except for deliberate back-to-back start strobes used to probe the busy rule. It also never writes the status offset in the same cycle as an interrupt event.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SOFT = 2'd1,
    MODE_SCAN = 2'd2,
    MODE_EXT  = 2'd3
  } conv_mode_e;

  // Field layout is decoded by the converter: diff at bit 7 down to channel at [3:0].
  typedef struct packed {
    logic       diff;
    logic       unipolar;
    logic [1:0] gain;
    logic [3:0] chan;
  } list_entry_t;

  localparam int ENTRY_W = 8;

  // Register word offsets.
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_CFG  = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;

  // Control word bits.
  localparam int CTL_GIE   = 15;
  localparam int CTL_EXTIE = 9;
  localparam int CTL_HFIE  = 8;

  // FIFO enable word bits.
  localparam int CFG_RES_EN  = 10;
  localparam int CFG_LIST_EN = 9;

  // Status word bits.
  localparam int STS_EXT_PEND = 9;
  localparam int STS_HF_PEND  = 8;
  localparam int STS_OVF      = 5;
  localparam int STS_FULL     = 4;
  localparam int STS_HALF     = 3;
  localparam int STS_EMPTY    = 2;
  localparam int STS_LFULL    = 1;
  localparam int STS_ACTIVE   = 0;

endpackage

// File: rtl/adc_chan_list.sv
module adc_chan_list
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          push,
  input  list_entry_t   push_entry,
  input  logic          advance,
  output list_entry_t   cur_entry,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  list_entry_t   slot [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] cur_q;
  logic [CW-1:0] cur_next;
  logic          do_push;

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign count     = cnt_q;
  assign do_push   = enable && push && !full;
  assign cur_next  = CW'(cur_q) + CW'(1);
  assign cur_entry = slot[cur_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (do_push && cnt_q == CW'(i)) slot[i] <= push_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else if (!enable) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else begin
      if (do_push) cnt_q <= cnt_q + CW'(1);
      if (advance && !empty) begin
        if (cur_next >= cnt_q) cur_q <= '0;
        else                   cur_q <= cur_next[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 12,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         half,
  output logic         overflow
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign half     = (cnt_q >= CW'(DEPTH / 2));
  assign overflow = ovf_q;
  assign head     = mem[rp_q];
  assign do_push  = enable && push && !full;
  assign do_pop   = enable && pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (!enable) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (push && full) ovf_q <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  conv_mode_e    mode,
  input  logic          sw_start,
  input  logic          scan_tick,
  input  logic          ext_rise,
  input  logic          list_empty,
  input  logic [CW-1:0] list_count,
  input  list_entry_t   cur_entry,
  input  logic          conv_done,
  output logic          conv_start,
  output list_entry_t   conv_entry,
  output logic          advance,
  output logic          busy
);

  logic [CW-1:0] left_q;
  logic          trig_one, trig_scan, launch, chain;

  assign trig_one  = (mode == MODE_SOFT && sw_start) || (mode == MODE_EXT && ext_rise);
  assign trig_scan = (mode == MODE_SCAN) && scan_tick;
  assign launch    = !busy && !list_empty && (trig_one || trig_scan);
  assign chain     = busy && conv_done && (left_q != '0) && !list_empty;
  assign advance   = launch || chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      conv_entry <= '0;
      busy       <= 1'b0;
      left_q     <= '0;
    end else begin
      conv_start <= advance;
      if (advance) conv_entry <= cur_entry;
      if (launch)         busy <= 1'b1;
      else if (conv_done) busy <= chain;
      if (launch)         left_q <= trig_scan ? list_count - CW'(1) : '0;
      else if (chain)     left_q <= left_q - CW'(1);
      else if (conv_done) left_q <= '0;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int LIST_DEPTH = 16,
  parameter int RES_DEPTH  = 32,
  parameter int SAMPLE_W   = 12,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                scan_tick,
  input  logic                ext_trig,
  output logic                conv_start,
  output logic [3:0]          conv_chan,
  output logic [1:0]          conv_gain,
  output logic                conv_unipolar,
  output logic                conv_diff,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_sample,
  output logic                irq
);

  localparam int LIST_CW = $clog2(LIST_DEPTH + 1);
  localparam logic [SAMPLE_W-1:0] MSB_FLIP = {1'b1, {(SAMPLE_W-1){1'b0}}};

  // Register state.
  conv_mode_e mode_q;
  logic gie_q, ext_ie_q, hf_ie_q;
  logic res_en_q, list_en_q;
  logic pend_ext_q, pend_hf_q;
  logic ext_q, hf_q;

  // Strobes.
  logic sel_ctrl, sel_cfg, sel_stat, sel_data;
  logic wr_ctrl, wr_cfg, pend_clr, list_push;
  logic sw_start, res_pop;
  logic ext_rise, hf_rise, pend_set;

  // Sub-block wiring.
  list_entry_t        cur_entry, conv_entry;
  logic               list_empty, list_full, seq_advance, seq_busy;
  logic [LIST_CW-1:0] list_cnt;
  logic [SAMPLE_W-1:0] res_head, res_ob;
  logic               res_empty, res_full, res_half, res_ovf;
  logic [DATA_W-1:0]  stat_word, data_word;
  logic               unused_wbits;

  assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_cfg   = (bus_addr == ADDR_W'(OFS_CFG));
  assign sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_data  = (bus_addr == ADDR_W'(OFS_DATA));
  assign wr_ctrl   = bus_wr && sel_ctrl;
  assign wr_cfg    = bus_wr && sel_cfg;
  assign pend_clr  = bus_wr && sel_stat;
  assign list_push = bus_wr && sel_data;
  assign sw_start  = bus_rd && sel_ctrl;
  assign res_pop   = bus_rd && sel_data;

  assign ext_rise = ext_trig && !ext_q;
  assign hf_rise  = res_half && !hf_q;
  assign pend_set = (ext_rise && ext_ie_q) || (hf_rise && hf_ie_q);

  assign unused_wbits = ^{bus_wdata[14:11], bus_wdata[7:2], bus_wdata[DATA_W-1:16]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_OFF;
      gie_q     <= 1'b0;
      ext_ie_q  <= 1'b0;
      hf_ie_q   <= 1'b0;
      res_en_q  <= 1'b0;
      list_en_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q   <= conv_mode_e'(bus_wdata[1:0]);
        gie_q    <= bus_wdata[CTL_GIE];
        ext_ie_q <= bus_wdata[CTL_EXTIE];
        hf_ie_q  <= bus_wdata[CTL_HFIE];
      end
      if (wr_cfg) begin
        res_en_q  <= bus_wdata[CFG_RES_EN];
        list_en_q <= bus_wdata[CFG_LIST_EN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q      <= 1'b0;
      hf_q       <= 1'b0;
      pend_ext_q <= 1'b0;
      pend_hf_q  <= 1'b0;
    end else begin
      ext_q      <= ext_trig;
      hf_q       <= res_half;
      pend_ext_q <= (pend_ext_q && !pend_clr) || (ext_rise && ext_ie_q);
      pend_hf_q  <= (pend_hf_q && !pend_clr) || (hf_rise && hf_ie_q);
    end
  end

  adc_chan_list #(.DEPTH(LIST_DEPTH)) u_list (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (list_en_q),
    .push       (list_push),
    .push_entry (list_entry_t'(bus_wdata[ENTRY_W-1:0])),
    .advance    (seq_advance),
    .cur_entry  (cur_entry),
    .empty      (list_empty),
    .full       (list_full),
    .count      (list_cnt)
  );

  adc_seq_engine #(.CW(LIST_CW)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .sw_start   (sw_start),
    .scan_tick  (scan_tick),
    .ext_rise   (ext_rise),
    .list_empty (list_empty),
    .list_count (list_cnt),
    .cur_entry  (cur_entry),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_entry (conv_entry),
    .advance    (seq_advance),
    .busy       (seq_busy)
  );

  adc_result_fifo #(.DEPTH(RES_DEPTH), .W(SAMPLE_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (res_en_q),
    .push      (conv_done),
    .push_data (conv_sample),
    .pop       (res_pop),
    .head      (res_head),
    .empty     (res_empty),
    .full      (res_full),
    .half      (res_half),
    .overflow  (res_ovf)
  );

  assign conv_chan     = conv_entry.chan;
  assign conv_gain     = conv_entry.gain;
  assign conv_unipolar = conv_entry.unipolar;
  assign conv_diff     = conv_entry.diff;
  assign irq           = gie_q && (pend_ext_q || pend_hf_q);

  assign res_ob = res_empty ? '0 : (res_head ^ MSB_FLIP);

  generate
    if (DATA_W > SAMPLE_W) begin : g_pad
      assign data_word = {{(DATA_W-SAMPLE_W){1'b0}}, res_ob};
    end else begin : g_fit
      assign data_word = res_ob[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    stat_word               = '0;
    stat_word[STS_ACTIVE]   = seq_busy;
    stat_word[STS_LFULL]    = list_full;
    stat_word[STS_EMPTY]    = res_empty;
    stat_word[STS_HALF]     = res_half;
    stat_word[STS_FULL]     = res_full;
    stat_word[STS_OVF]      = res_ovf;
    stat_word[STS_HF_PEND]  = pend_hf_q;
    stat_word[STS_EXT_PEND] = pend_ext_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_stat)      bus_rdata = stat_word;
    else if (sel_data) bus_rdata = data_word;
  end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        busy,
  input logic        conv_start,
  input logic        list_empty,
  input logic        list_en,
  input logic        res_en,
  input logic [15:0] stat,
  input logic        gie,
  input logic        irq,
  input logic        pend_clr,
  input logic        pend_set
);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);                                   // R2
  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !busy) |=> !conv_start);                      // R1
  AST_EMPTY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (list_empty && !busy) |=> !conv_start);                        // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[4] && stat[2]));                                        // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[5] && res_en) |=> stat[5]);                              // R10
  AST_LIST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !list_en |=> list_empty);                                      // R11
  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_en |=> (stat[2] && !stat[5]));                            // R11
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);                                                // R12
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !pend_set) |=> (stat[9:8] == 2'b00));             // R13

endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode_q),
  .busy       (seq_busy),
  .conv_start (conv_start),
  .list_empty (list_empty),
  .list_en    (list_en_q),
  .res_en     (res_en_q),
  .stat       (stat_word),
  .gie        (gie_q),
  .irq        (irq),
  .pend_clr   (pend_clr),
  .pend_set   (pend_set)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        scan_tick = 1'b0, ext_trig = 1'b0;
  logic        conv_start, conv_unipolar, conv_diff, irq;
  logic [3:0]  conv_chan;
  logic [1:0]  conv_gain;
  logic        conv_done = 1'b0;
  logic [11:0] conv_sample = '0;

  always #5 clk = ~clk;

  adc_seq_ctrl u0 (.*);

  int checks = 0, fails = 0, starts = 0;
  bit finished = 1'b0;
  logic [7:0]  exp_conv_q[$];
  logic [11:0] exp_res_q[$];
  logic [7:0]  mlist[16];
  int mcnt = 0, mcur = 0;
  bit mlist_en = 1'b0, mres_en = 1'b0;
  logic [3:0] seq_n = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [15:0] d);
    bus_write(2'd1, d);
    mlist_en = d[9];
    mres_en  = d[10];
    if (!mlist_en) begin mcnt = 0; mcur = 0; end
    if (!mres_en) exp_res_q.delete();
  endtask

  task automatic push_entry(input logic [7:0] e);
    bus_write(2'd3, {8'h00, e});
    if (mlist_en && mcnt < 16) begin mlist[mcnt] = e; mcnt++; end
  endtask

  // Driver side of the scoreboard: expected request fields.
  task automatic expect_launch();
    if (mcnt > 0) begin
      exp_conv_q.push_back(mlist[mcur]);
      mcur = (mcur + 1 >= mcnt) ? 0 : mcur + 1;
    end
  endtask

  task automatic expect_status(input logic [15:0] e, input string req);
    logic [15:0] d;
    bus_read(2'd2, d);
    chk(d == e, req, d, e);
  endtask

  task automatic drain(input int n, input string req);
    logic [15:0] d;
    for (int i = 0; i < n; i++) begin
      logic [15:0] e;
      e = (exp_res_q.size() > 0) ? {4'h0, exp_res_q.pop_front()} : 16'h0000;
      bus_read(2'd3, d);
      chk(d == e, req, d, e);
    end
  endtask

  task automatic sw_start_one();
    logic [15:0] d;
    expect_launch();
    bus_read(2'd0, d);
    chk(d == 16'h0000, "R2 start read data", d, 0);
    settle(6);
  endtask

  task automatic scan_once();
    for (int i = 0; i < mcnt; i++) expect_launch();
    @(negedge clk); scan_tick = 1'b1;
    @(negedge clk); scan_tick = 1'b0;
    settle(30);
  endtask

  // Converter model and monitor: compares request fields, returns a sample.
  initial begin
    logic [7:0]  f;
    logic [11:0] s;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (conv_start) begin
        starts++;
        f = {conv_diff, conv_unipolar, conv_gain, conv_chan};
        if (exp_conv_q.size() == 0) chk(1'b0, "R7 unexpected conv_start", f, 0);
        else begin
          logic [7:0] e;
          e = exp_conv_q.pop_front();
          chk(f == e, "R3 R4 request fields", f, e);
        end
        s = {f, seq_n};
        seq_n++;
        repeat (2) @(negedge clk);
        conv_sample = s;
        conv_done = 1'b1;
        if (mres_en) begin
          if (exp_res_q.size() < 32) exp_res_q.push_back(s ^ 12'h800);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    settle(3);
    rst_n = 1'b1;
    settle(2);
    expect_status(16'h0004, "R9 reset status");
    chk(irq == 1'b0, "R12 reset irq", irq, 0);

    set_cfg(16'h0600);
    push_entry(8'h05); push_entry(8'h3A); push_entry(8'h4F); push_entry(8'h81);

    // R1: mode 0 ignores every trigger.
    bus_read(2'd0, d);
    @(negedge clk); scan_tick = 1'b1; ext_trig = 1'b1;
    @(negedge clk); scan_tick = 1'b0; ext_trig = 1'b0;
    settle(8);
    chk(starts == 0, "R1 no start in mode 0", starts, 0);

    // R2: software mode ignores scan and external triggers.
    bus_write(2'd0, 16'h0001);
    @(negedge clk); scan_tick = 1'b1; ext_trig = 1'b1;
    @(negedge clk); scan_tick = 1'b0; ext_trig = 1'b0;
    settle(8);
    chk(starts == 0, "R2 other triggers ignored", starts, 0);
    for (int i = 0; i < 5; i++) sw_start_one();
    chk(starts == 5, "R2 one conversion per strobe", starts, 5);

    // R8: offset-binary readout and empty read.
    expect_status(16'h0000, "R9 five results");
    drain(5, "R8 result readout");
    bus_read(2'd3, d);
    chk(d == 16'h0000, "R8 empty read", d, 0);
    expect_status(16'h0004, "R8 empty unchanged");

    // R7: second strobe while busy is ignored.
    expect_launch();
    @(negedge clk); bus_addr = 2'd0; bus_rd = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_rd = 1'b0;
    settle(8);
    chk(starts == 6, "R7 busy strobe ignored", starts, 6);
    drain(1, "R8 readout after busy test");

    // R5: scan converts the whole list from the cursor.
    bus_write(2'd0, 16'h0002);
    scan_once();
    chk(starts == 10, "R5 scan count", starts, 10);
    drain(4, "R5 scan results");

    // R6, R12, R13: external edge, pending flag, clear.
    bus_write(2'd0, 16'h8303);
    expect_launch();
    @(negedge clk); ext_trig = 1'b1;
    settle(3);
    @(negedge clk); ext_trig = 1'b0;
    settle(8);
    chk(starts == 11, "R6 one conversion per edge", starts, 11);
    expect_status(16'h0200, "R12 external pending");
    chk(irq == 1'b1, "R12 irq raised", irq, 1);
    bus_write(2'd2, 16'h0000);
    expect_status(16'h0000, "R13 pending cleared");
    chk(irq == 1'b0, "R13 irq dropped", irq, 0);
    drain(1, "R8 external result");

    // R10, R12: fill past half and past full.
    bus_write(2'd0, 16'h8102);
    for (int i = 0; i < 4; i++) scan_once();
    expect_status(16'h0108, "R12 half-full pending");
    chk(irq == 1'b1, "R12 half-full irq", irq, 1);
    for (int i = 0; i < 5; i++) scan_once();
    expect_status(16'h0138, "R10 full with overflow");
    drain(32, "R10 retained samples");
    expect_status(16'h0124, "R10 overflow sticky");
    bus_write(2'd2, 16'h0000);
    expect_status(16'h0024, "R13 clear keeps overflow");

    // R11: disabling the result FIFO flushes it and the overflow flag.
    set_cfg(16'h0200);
    settle(2);
    expect_status(16'h0004, "R11 result flush");
    set_cfg(16'h0600);

    // R11: disabling the list flushes it and drops writes.
    set_cfg(16'h0400);
    push_entry(8'h12);
    set_cfg(16'h0600);
    bus_write(2'd0, 16'h0001);
    bus_read(2'd0, d);
    settle(8);
    chk(starts == 47, "R11 list flushed, R7 empty list", starts, 47);

    // R4: full list, dropped write, wrap after entry 15.
    for (int i = 0; i < 16; i++) push_entry(8'((i * 37) & 8'hFF));
    expect_status(16'h0006, "R9 list full");
    push_entry(8'hFF);
    for (int i = 0; i < 17; i++) sw_start_one();
    chk(starts == 64, "R4 seventeen conversions", starts, 64);
    expect_status(16'h000A, "R9 half and list full");
    drain(17, "R8 final readout");
    set_cfg(16'h0000);
    settle(2);
    expect_status(16'h0004, "R11 final flush");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule